// File: doc/BRIEF.md
# Ethernet receive destination-address filter

The block decides, frame by frame, whether a received Ethernet frame is kept or dropped, from its 48-bit destination address. Address bytes arrive one per strobe after a start-of-frame pulse. The filter assembles the address and runs a byte-serial CRC over it. One cycle after the sixth byte it gives a verdict with four parts: accept or reject, a miss flag for frames kept only because promiscuous mode is on, and a flag for a PAUSE candidate.

The filter holds two 64-bit hash tables, one for group addresses and one for individual addresses, and each is loaded in 32-bit halves. A write is held in a staging copy until the next start-of-frame, so a frame is always judged against one consistent table. A separate frame parser supplies the "valid PAUSE frame" flag, and a PAUSE candidate confirmed by that flag is rejected.

Top module: `rx_addr_filter`

## Requirements
- R1: The first address byte on the wire fills bits 47:40 of the assembled address. Bit 0 of that byte (bit 40) set marks a group address and clear marks an individual address. Only the table that belongs to the class is consulted.
- R2: An all-ones address with `bc_reject_i` low is accepted with `miss_o` low, whatever the tables, flow control or promiscuous mode.
- R3: An all-ones address with `bc_reject_i` high is accepted with `miss_o` high when `promisc_i` is high, and is rejected otherwise. The tables are not consulted.
- R4: A group address with `flow_ctrl_en_i` low is accepted when bit k of the group table is set. k is bits 31:26 of a CRC-32 register that starts at all ones and is shifted right once per address bit, least significant bit of each byte first, with the reflected polynomial 0xEDB88320 and no final inversion.
- R5: With `flow_ctrl_en_i` high, a group address counts as matched only when it equals 01:80:C2:00:00:01. The group table is ignored.
- R6: `pause_cand_o` is high when flow control is enabled and the address equals either the PAUSE address or `station_addr_i`. If `pause_valid_i` is also high in the cycle after the sixth byte, the frame is rejected with `miss_o` low, even in promiscuous mode.
- R7: An individual address is accepted when it equals `station_addr_i` (bits 47:40 = first byte) or when bit k of the individual table is set (k as in R4).
- R8: A non-broadcast frame that matches nothing is accepted with `miss_o` high when `promisc_i` is high, and is rejected otherwise. `miss_o` is never high without `accept_o`.
- R9: `decision_valid_o` pulses for exactly one cycle, one clock after the edge that takes the sixth byte. At that point exactly one of `accept_o` and `reject_o` is high. The verdict outputs stay unchanged until the next `sof_i`, and `sof_i` clears them to zero. Reset leaves every output low.
- R10: A table write (`tbl_sel_i[1]`: 0 group, 1 individual; `tbl_sel_i[0]`: 1 bits 63:32, 0 bits 31:0) takes effect at the next `sof_i`. It does not change the verdict of the frame in progress.
- R11: `sof_i` restarts byte counting and the CRC, even in the middle of an address. Bytes after the sixth have no effect, and a byte presented together with `sof_i` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame pulse |
| byte_valid_i | input | 1 | Address byte strobe |
| byte_i | input | 8 | Received byte |
| bc_reject_i | input | 1 | Reject broadcast frames |
| promisc_i | input | 1 | Promiscuous mode |
| flow_ctrl_en_i | input | 1 | Flow control enabled |
| station_addr_i | input | 48 | Own unicast address, first wire byte in 47:40 |
| pause_valid_i | input | 1 | Frame confirmed as a valid PAUSE frame |
| tbl_we_i | input | 1 | Hash table write enable |
| tbl_sel_i | input | 2 | Table and half select |
| tbl_wdata_i | input | 32 | Hash table write data |
| decision_valid_o | output | 1 | One-cycle verdict pulse |
| accept_o | output | 1 | Frame kept |
| reject_o | output | 1 | Frame dropped |
| miss_o | output | 1 | Kept only through promiscuous mode |
| pause_cand_o | output | 1 | Address qualifies as PAUSE destination |

## Verification
The verdict is due in the cycle after the clock edge that captures the sixth byte. The bench drives on falling edges and samples at the falling edge after that cycle, where `decision_valid_o` must be high. It samples again one cycle later, where the pulse must be gone and the verdict must be unchanged. Table writes become visible only at the `sof_i` edge after them, so the bench writes tables before each frame's start pulse, except in the test that deliberately writes mid-frame and then repeats the frame. Trailing bytes and the `sof_i` clear are each checked in the cycle after the edge that takes them.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam logic [ADDR_W-1:0] PAUSE_DA = 48'h0180_C200_0001;
  localparam logic [31:0]       CRC_POLY = 32'hEDB8_8320;

  typedef struct packed {
    logic accept;
    logic reject;
    logic miss;
    logic pause_cand;
  } verdict_t;
endpackage

// File: rtl/rx_addr_crc.sv
module rx_addr_crc #(
  parameter int HASH_BITS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic [7:0]           byte_i,
  output logic [HASH_BITS-1:0] idx_o
);
  import rx_filt_pkg::*;

  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    for (int b = 0; b < 8; b++) begin
      if (crc_d[0] ^ byte_i[b]) crc_d = (crc_d >> 1) ^ CRC_POLY;
      else                      crc_d = crc_d >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '1;
    else if (clr_i) crc_q <= '1;
    else if (en_i)  crc_q <= crc_d;
  end

  assign idx_o = crc_q[31 -: HASH_BITS];
endmodule

// File: rtl/rx_hash_tables.sv
module rx_hash_tables #(
  parameter int HASH_BITS = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sof_i,
  input  logic                   we_i,
  input  logic [1:0]             sel_i,
  input  logic [(2**HASH_BITS)/2-1:0] wdata_i,
  input  logic [HASH_BITS-1:0]   idx_i,
  output logic [1:0]             hit_o   // [0] group, [1] individual
);
  localparam int TBL  = 2 ** HASH_BITS;
  localparam int HALF = TBL / 2;

  for (genvar g = 0; g < 2; g++) begin : g_tbl
    logic [TBL-1:0] stg_q, act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q <= '0;
        act_q <= '0;
      end else begin
        if (we_i && sel_i[1] == 1'(g)) begin
          if (sel_i[0]) stg_q[TBL-1:HALF] <= wdata_i;
          else          stg_q[HALF-1:0]   <= wdata_i;
        end
        if (sof_i) act_q <= stg_q;   // tables frozen for the whole frame
      end
    end

    assign hit_o[g] = act_q[idx_i];
  end
endmodule

// File: rtl/rx_addr_decide.sv
module rx_addr_decide
  import rx_filt_pkg::*;
(
  input  logic [ADDR_W-1:0] da_i,
  input  logic [ADDR_W-1:0] station_i,
  input  logic              bc_reject_i,
  input  logic              promisc_i,
  input  logic              flow_ctrl_en_i,
  input  logic              pause_valid_i,
  input  logic              grp_hit_i,
  input  logic              ind_hit_i,
  output verdict_t          verdict_o
);
  logic is_bc, is_grp, p_match, s_match, hit;

  assign is_bc   = &da_i;
  assign is_grp  = da_i[ADDR_W-8];
  assign p_match = (da_i == PAUSE_DA);
  assign s_match = (da_i == station_i);
  assign hit     = is_grp ? (flow_ctrl_en_i ? p_match : grp_hit_i)
                          : (s_match | ind_hit_i);

  always_comb begin
    verdict_o            = '0;
    verdict_o.pause_cand = flow_ctrl_en_i & (p_match | s_match);
    if (is_bc && !bc_reject_i) begin
      verdict_o.accept = 1'b1;
    end else if (verdict_o.pause_cand && pause_valid_i) begin
      verdict_o.reject = 1'b1;
    end else if (!is_bc && hit) begin
      verdict_o.accept = 1'b1;
    end else if (promisc_i) begin
      verdict_o.accept = 1'b1;
      verdict_o.miss   = 1'b1;
    end else begin
      verdict_o.reject = 1'b1;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int HASH_BITS = 6,
  localparam int WR_W     = (2 ** HASH_BITS) / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              bc_reject_i,
  input  logic              promisc_i,
  input  logic              flow_ctrl_en_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic              pause_valid_i,
  input  logic              tbl_we_i,
  input  logic [1:0]        tbl_sel_i,
  input  logic [WR_W-1:0]   tbl_wdata_i,
  output logic              decision_valid_o,
  output logic              accept_o,
  output logic              reject_o,
  output logic              miss_o,
  output logic              pause_cand_o
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0]     cnt_q;
  logic [ADDR_W-1:0]    da_q;
  logic                 capture, eval_q;
  logic [HASH_BITS-1:0] idx;
  logic [1:0]           hit;
  verdict_t             vd, vd_q;
  logic                 dv_q;

  assign capture = byte_valid_i && !sof_i && (cnt_q < CNT_W'(ADDR_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      da_q   <= '0;
      eval_q <= 1'b0;
    end else if (sof_i) begin
      cnt_q  <= '0;
      da_q   <= '0;
      eval_q <= 1'b0;
    end else begin
      eval_q <= capture && (cnt_q == CNT_W'(ADDR_BYTES - 1));
      if (capture) begin
        cnt_q <= cnt_q + 1'b1;
        da_q  <= {da_q[ADDR_W-9:0], byte_i};
      end
    end
  end

  rx_addr_crc #(.HASH_BITS(HASH_BITS)) u_crc (
    .clk_i, .rst_ni, .clr_i(sof_i), .en_i(capture), .byte_i, .idx_o(idx)
  );

  rx_hash_tables #(.HASH_BITS(HASH_BITS)) u_tbl (
    .clk_i, .rst_ni, .sof_i, .we_i(tbl_we_i), .sel_i(tbl_sel_i),
    .wdata_i(tbl_wdata_i), .idx_i(idx), .hit_o(hit)
  );

  rx_addr_decide u_dec (
    .da_i(da_q), .station_i(station_addr_i), .bc_reject_i, .promisc_i,
    .flow_ctrl_en_i, .pause_valid_i, .grp_hit_i(hit[0]), .ind_hit_i(hit[1]),
    .verdict_o(vd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vd_q <= '0;
      dv_q <= 1'b0;
    end else if (sof_i) begin
      vd_q <= '0;
      dv_q <= 1'b0;
    end else begin
      dv_q <= eval_q;
      if (eval_q) vd_q <= vd;
    end
  end

  assign decision_valid_o = dv_q;
  assign accept_o         = vd_q.accept;
  assign reject_o         = vd_q.reject;
  assign miss_o           = vd_q.miss;
  assign pause_cand_o     = vd_q.pause_cand;
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sof_i,
  input logic        bc_reject_i,
  input logic        pause_valid_i,
  input logic        eval_q,
  input logic [47:0] da_q,
  input logic        decision_valid_o,
  input logic        accept_o,
  input logic        reject_o,
  input logic        miss_o,
  input logic        pause_cand_o
);
  assert_one_verdict_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |-> (accept_o ^ reject_o));

  assert_pulse_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |=> !decision_valid_o);

  assert_due_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_q && !sof_i) |=> decision_valid_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sof_i && !eval_q) |=> $stable({accept_o, reject_o, miss_o, pause_cand_o}));

  assert_sof_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> !(accept_o || reject_o || miss_o || decision_valid_o));

  assert_miss_implies_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> accept_o);

  assert_bcast_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && (&da_q) && !$past(bc_reject_i)) |-> (accept_o && !miss_o));

  assert_pause_reject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && pause_cand_o && $past(pause_valid_i)) |-> (reject_o && !miss_o));
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (.*);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 0, bv = 0, bcrej = 0, prom = 0, flow = 0, pv = 0, we = 0;
  logic [7:0]  byt = '0;
  logic [47:0] sta = 48'h0A1B_2C3D_4E5F;
  logic [1:0]  sel = '0;
  logic [31:0] wd = '0;
  logic        dv, acc, rej, miss, pc;

  int tests = 0, fails = 0;

  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] PS = 48'h0180_C200_0001;
  localparam logic [47:0] ST = 48'h0A1B_2C3D_4E5F;
  localparam logic [47:0] MC = 48'h0300_5E12_3456;
  localparam logic [47:0] UC = 48'h02AA_BBCC_DDEE;

  always #2 clk = ~clk;

  rx_addr_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .byte_valid_i(bv), .byte_i(byt),
    .bc_reject_i(bcrej), .promisc_i(prom), .flow_ctrl_en_i(flow),
    .station_addr_i(sta), .pause_valid_i(pv), .tbl_we_i(we), .tbl_sel_i(sel),
    .tbl_wdata_i(wd), .decision_valid_o(dv), .accept_o(acc), .reject_o(rej),
    .miss_o(miss), .pause_cand_o(pc)
  );

  typedef struct packed {
    logic [47:0] da;
    logic bcr, prm, flw, pvl, gfil, ifil, eacc, emis, epc;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{BC, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R2
    '{BC, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R2
    '{BC, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b0}, // R3
    '{BC, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0}, // R3
    '{MC, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0}, // R4
    '{MC, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0}, // R1
    '{MC, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0}, // R8
    '{MC, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0}, // R5
    '{PS, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1}, // R5
    '{PS, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1}, // R6
    '{PS, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0}, // R6
    '{ST, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R7
    '{ST, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1}, // R6
    '{UC, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0}, // R7
    '{UC, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0}, // R1
    '{UC, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0}, // R8
    '{UC, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b0}  // R6
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  function automatic logic [5:0] hidx(input logic [47:0] da);
    logic [31:0] c = '1;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = da[47-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ b[j];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return c[31:26];
  endfunction

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); we = 1; sel = s; wd = d;
    @(negedge clk); we = 0;
  endtask

  task automatic load(input logic [63:0] g, input logic [63:0] i);
    wr(2'b00, g[31:0]); wr(2'b01, g[63:32]);
    wr(2'b10, i[31:0]); wr(2'b11, i[63:32]);
  endtask

  task automatic start_frame();
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0;
  endtask

  // leaves at the falling edge after the verdict edge
  task automatic send_addr(input logic [47:0] da);
    for (int i = 0; i < 6; i++) begin
      bv = 1; byt = da[47-8*i -: 8];
      @(negedge clk);
    end
    bv = 0;
    @(negedge clk);
  endtask

  function automatic logic [63:0] onehot(input logic [5:0] k);
    return 64'd1 << k;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [4:0] hold;
    logic [5:0] k;
    repeat (3) @(negedge clk);
    chk({dv,acc,rej,miss,pc} == 5'b0, "R9 reset", {dv,acc,rej,miss,pc}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({dv,acc,rej,miss,pc} == 5'b0, "R9 after reset", {dv,acc,rej,miss,pc}, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      load(t.gfil ? '1 : '0, t.ifil ? '1 : '0);
      bcrej = t.bcr; prom = t.prm; flow = t.flw; pv = t.pvl;
      start_frame();
      send_addr(t.da);
      chk({dv,acc,rej,miss,pc} == {1'b1,t.eacc,!t.eacc,t.emis,t.epc},
          $sformatf("R9/vector %0d verdict", v),
          {dv,acc,rej,miss,pc}, {1'b1,t.eacc,!t.eacc,t.emis,t.epc});
      @(negedge clk);
      chk({dv,acc,rej,miss,pc} == {1'b0,t.eacc,!t.eacc,t.emis,t.epc},
          $sformatf("R9 hold vector %0d", v),
          {dv,acc,rej,miss,pc}, {1'b0,t.eacc,!t.eacc,t.emis,t.epc});
    end
    bcrej = 0; prom = 0; flow = 0; pv = 0;

    // R4: exact hash bit for a group address
    k = hidx(MC);
    load(onehot(k), '0); start_frame(); send_addr(MC);
    chk(acc === 1'b1, "R4 group hash bit hit", acc, 1);
    load(onehot(k ^ 6'd1), '0); start_frame(); send_addr(MC);
    chk(rej === 1'b1, "R4 neighbour bit miss", rej, 1);

    // R7: exact hash bit for an individual address
    k = hidx(UC);
    load('0, onehot(k)); start_frame(); send_addr(UC);
    chk(acc === 1'b1, "R7 individual hash bit hit", acc, 1);
    load('0, onehot(k ^ 6'd32)); start_frame(); send_addr(UC);
    chk(rej === 1'b1, "R7 individual neighbour miss", rej, 1);

    // R10: write after sof affects only the next frame
    load('0, '0);
    start_frame();
    load('1, '0);
    send_addr(MC);
    chk(rej === 1'b1, "R10 mid-frame write not applied", rej, 1);
    start_frame(); send_addr(MC);
    chk(acc === 1'b1, "R10 write applied next frame", acc, 1);

    // R11: trailing bytes ignored
    hold = {dv,acc,rej,miss,pc};
    for (int i = 0; i < 4; i++) begin
      bv = 1; byt = 8'hFF; @(negedge clk);
    end
    bv = 0; @(negedge clk);
    chk({dv,acc,rej,miss,pc} == {1'b0,hold[3:0]}, "R11 trailing bytes ignored",
        {dv,acc,rej,miss,pc}, {1'b0,hold[3:0]});

    // R9: sof clears outputs
    start_frame();
    chk({dv,acc,rej,miss,pc} == 5'b0, "R9 sof clears", {dv,acc,rej,miss,pc}, 0);

    // R11: sof mid-address restarts counting
    load('0, '0); start_frame();
    for (int i = 0; i < 3; i++) begin
      bv = 1; byt = ST[47-8*i -: 8]; @(negedge clk);
    end
    bv = 0;
    start_frame();
    for (int i = 0; i < 3; i++) begin
      bv = 1; byt = UC[47-8*i -: 8]; @(negedge clk);
    end
    bv = 0; @(negedge clk);
    chk(dv === 1'b0, "R11 no early verdict after restart", dv, 0);
    for (int i = 3; i < 6; i++) begin
      bv = 1; byt = UC[47-8*i -: 8]; @(negedge clk);
    end
    bv = 0; @(negedge clk);
    chk({dv,acc,rej} == 3'b101, "R11 restarted frame verdict", {dv,acc,rej}, 3'b101);

    // R11: byte together with sof dropped
    load('0, '0); @(negedge clk);
    sof = 1; bv = 1; byt = 8'h55; @(negedge clk);
    sof = 0; bv = 0;
    send_addr(ST);
    chk({dv,acc} == 2'b11, "R11 byte with sof dropped", {dv,acc}, 2'b11);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule